// File: doc/BRIEF.md
# Per-VC Credit Flow Controller

This block sits at the sending end of a link that carries several virtual channels (VCs). For each VC it keeps a count of the flit buffers that are still free at the receiving node. Every flit sent on a VC uses up one of that VC's credits. The receiver hands a credit back each time it frees a buffer, and the block adds that credit to the count of the matching VC.

The block drives one send-allowed line per VC to the switch allocator. The line is high only while the VC has at least one credit. A send request aimed at a VC with no credits is ignored, so a flit is never sent into a full receive buffer. The receive buffer depth per VC is a parameter, and it is also the value each counter takes at reset. The receive buffer depth must be larger than the credit round trip, or the link stalls even when nothing else is in the way.

Top module: `credit_link_ctrl`

## Requirements
- R1: After reset every VC holds DEPTH credits. Every `snd_ok` bit is high, and each VC accepts exactly DEPTH sends before its `snd_ok` bit falls.
- R2: A send is accepted when `snd_req` is high, `snd_vc` selects VC v (binary index) and `snd_ok[v]` is high. An accepted send lowers the credit count of VC v by one and leaves every other VC unchanged.
- R3: `snd_ok[v]` is low exactly when VC v has zero credits. A send request to such a VC is ignored, and the count stays at zero.
- R4: A credit return, with `crd_rtn` high and `crd_vc` = v, raises the count of VC v by one.
- R5: If an accepted send and a credit return hit the same VC in the same cycle, its count does not change.
- R6: A count never goes above DEPTH. Once a drained VC has DEPTH credits returned, it accepts exactly DEPTH sends and no more.
- R7: Suppose each credit comes back L cycles after the cycle of its send. If L < DEPTH, a VC that is requested every cycle never stalls. If L = DEPTH, it stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snd_req | input | 1 | A flit wants to go out this cycle |
| snd_vc | input | VCW | VC index of the requesting flit |
| snd_ok | output | NUM_VC | Per-VC send allowed (VC has at least one credit) |
| crd_rtn | input | 1 | Receiver returns one credit this cycle |
| crd_vc | input | VCW | VC index of the returned credit |

## Verification
The hardest states to reach from the ports are the ones where one VC sits at a chosen count, from zero up to DEPTH, while a send and a credit arrive together. At that moment the count cannot be seen directly. The bench drains the VC from reset by a known number of sends to reach each starting count. It then applies each of the four combinations of send and credit, and reads the resulting count back by counting how many sends are accepted before `snd_ok` falls. A credit-echo loop with delays DEPTH-1 and DEPTH probes the round-trip boundary. A long constrained-random run compares all VCs against an arithmetic model of the counts.

// File: rtl/credit_pkg.sv
// Shared types for the per-VC credit flow controller.
package credit_pkg;
    // Update applied to one credit counter in a cycle.
    typedef enum logic [1:0] {
        CR_HOLD = 2'd0,
        CR_DEC  = 2'd1,
        CR_INC  = 2'd2
    } cr_op_e;
endpackage

// File: rtl/vc_onehot_dec.sv
// Turns a valid strobe plus a binary VC index into a one-hot vector.
// Assumes: an index at or above NUM_VC gives an all-zero vector.
module vc_onehot_dec #(
    parameter int NUM_VC = 4,
    parameter int VCW    = 2
) (
    input  logic              vld_i,
    input  logic [VCW-1:0]    idx_i,
    output logic [NUM_VC-1:0] hot_o
);
    // One comparator per VC.
    for (genvar g = 0; g < NUM_VC; g++) begin : g_dec
        assign hot_o[g] = vld_i && (idx_i == VCW'(g));
    end
endmodule

// File: rtl/vc_credit_cnt.sv
// Credit counter for one VC. It starts at DEPTH, a taken send lowers it,
// a returned credit raises it, and the two together cancel out.
// Assumes: take_i is only asserted while ok_o is high. A credit returned
// at DEPTH with no send in the same cycle is a protocol error; the count
// is held at DEPTH and an assertion reports it.
module vc_credit_cnt
    import credit_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic take_i,
    input  logic rtn_i,
    output logic ok_o
);
    logic [CW-1:0] cnt_q;
    cr_op_e        op;

    // Choose this cycle's update from the send and credit strobes.
    always_comb begin
        op = CR_HOLD;
        if (take_i && !rtn_i)
            op = CR_DEC;
        else if (rtn_i && !take_i && (cnt_q < CW'(DEPTH)))
            op = CR_INC;
    end

    // Credit count register, loaded with the full depth on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CW'(DEPTH);
        else if (op == CR_DEC)
            cnt_q <= cnt_q - 1'b1;
        else if (op == CR_INC)
            cnt_q <= cnt_q + 1'b1;
    end

    // Send allowed while any credit is left.
    assign ok_o = (cnt_q != '0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rtn_i && !take_i && (cnt_q == CW'(DEPTH))));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !take_i);
    // R3
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (cnt_q == '0) && !rtn_i) |=> (cnt_q == '0));
    // R2
    send_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !rtn_i) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));
    // R4
    rtn_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtn_i && !take_i && (cnt_q < CW'(DEPTH))) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
    // R5
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtn_i && take_i) |=> $stable(cnt_q));
endmodule

// File: rtl/credit_link_ctrl.sv
// Upstream credit flow controller: one credit counter per VC. A send to a
// VC is taken only if that VC still has a credit, so the receive buffers
// never overflow.
// Assumes: DEPTH is larger than the credit round trip if full rate is
// wanted. The send requester obeys snd_ok, but a request to a blocked VC
// is ignored anyway.
module credit_link_ctrl #(
    parameter int NUM_VC = 4,
    parameter int DEPTH  = 4,
    localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_req,
    input  logic [VCW-1:0]    snd_vc,
    output logic [NUM_VC-1:0] snd_ok,
    input  logic              crd_rtn,
    input  logic [VCW-1:0]    crd_vc
);
    logic [NUM_VC-1:0] snd_hot;
    logic [NUM_VC-1:0] crd_hot;
    logic [NUM_VC-1:0] take;

    vc_onehot_dec #(.NUM_VC(NUM_VC), .VCW(VCW)) u_snd_dec (
        .vld_i(snd_req), .idx_i(snd_vc), .hot_o(snd_hot));
    vc_onehot_dec #(.NUM_VC(NUM_VC), .VCW(VCW)) u_crd_dec (
        .vld_i(crd_rtn), .idx_i(crd_vc), .hot_o(crd_hot));

    // Gate each request by its VC's credit state.
    always_comb take = snd_hot & snd_ok;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        vc_credit_cnt #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (snd_hot[g]),
            .take_i(take[g]),
            .rtn_i (crd_hot[g]),
            .ok_o  (snd_ok[g]));
    end

    // R2
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/credit_link_ctrl_tb.sv
module credit_link_ctrl_tb;
    localparam int NV = 4;
    localparam int D  = 4;
    localparam int VW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_req = 1'b0;
    logic [VW-1:0] snd_vc = '0;
    logic [NV-1:0] snd_ok;
    logic          crd_rtn = 1'b0;
    logic [VW-1:0] crd_vc = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    credit_link_ctrl #(.NUM_VC(NV), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_vc(snd_vc),
        .snd_ok(snd_ok), .crd_rtn(crd_rtn), .crd_vc(crd_vc));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock with the given strobes; they are dropped after the edge.
    task automatic cyc(bit sr, int sv, bit cr, int cv);
        @(negedge clk);
        snd_req = sr; snd_vc = VW'(sv); crd_rtn = cr; crd_vc = VW'(cv);
        @(posedge clk); #1;
        snd_req = 0; crd_rtn = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
    endtask

    // Read a VC's count through the ports: sends accepted until snd_ok falls.
    task automatic read_count(int v, output int n);
        n = 0;
        for (int i = 0; i < D + 2; i++) begin
            @(negedge clk);
            if (!snd_ok[v]) break;
            n++;
            cyc(1, v, 0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n, n2, exp, stalls, tag;
        int model [NV];
        bit hist [0:63];

        // R1: reset state and full depth per VC
        do_reset();
        @(negedge clk);
        chk("R1 snd_ok after reset", int'(snd_ok), (1 << NV) - 1);
        for (int v = 0; v < NV; v++) begin
            read_count(v, n);
            chk("R1 depth per VC", n, D);
        end

        // Matrix: each VC, each start count, each send/credit combination
        for (int v = 0; v < NV; v++)
            for (int c = 0; c <= D; c++)
                for (int s = 0; s < 2; s++)
                    for (int r = 0; r < 2; r++) begin
                        if (r == 1 && c == D && !(s == 1 && c > 0)) continue;
                        do_reset();
                        for (int k = 0; k < D - c; k++) cyc(1, v, 0, 0);
                        cyc(s[0], v, r[0], v);
                        exp = c - ((s == 1 && c > 0) ? 1 : 0) + r;
                        read_count(v, n);
                        read_count((v + 1) % NV, n2);
                        if (s == 1 && r == 1) begin
                            if (c > 0) chk("R5 send+credit same VC", n, exp);
                            else       chk("R4 credit with blocked send", n, exp);
                        end else if (s == 1 && c == 0) chk("R3 send at zero ignored", n, exp);
                        else if (r == 1) chk("R4 credit increments", n, exp);
                        else if (s == 1) chk("R2 send decrements", n, exp);
                        else chk("R1 idle holds count", n, exp);
                        chk("R2 other VC untouched", n2, D);
                    end

        // R3: zero-credit VC shows snd_ok low and ignores a send
        do_reset();
        for (int k = 0; k < D; k++) cyc(1, 2, 0, 0);
        @(negedge clk);
        chk("R3 snd_ok low at zero", int'(snd_ok[2]), 0);
        cyc(1, 2, 0, 0);
        cyc(0, 0, 1, 2);
        read_count(2, n);
        chk("R3 ignored send left count at zero", n, 1);

        // R6: refill from zero stops at depth
        do_reset();
        for (int k = 0; k < D; k++) cyc(1, 1, 0, 0);
        for (int k = 0; k < D; k++) cyc(0, 0, 1, 1);
        read_count(1, n);
        chk("R6 refill reaches depth only", n, D);

        // R7: credit echo with delay L, sending on VC0 every cycle
        for (int L = D - 1; L <= D; L++) begin
            do_reset();
            stalls = 0;
            for (int t = 0; t < 40; t++) begin
                @(negedge clk);
                hist[t] = snd_ok[0];
                if (!snd_ok[0]) stalls++;
                snd_req = 1; snd_vc = 0;
                crd_rtn = (t >= L) && hist[t - L]; crd_vc = 0;
                @(posedge clk); #1;
            end
            snd_req = 0; crd_rtn = 0;
            if (L < D) chk("R7 full rate when L<DEPTH", stalls, 0);
            else       chk("R7 stalls when L=DEPTH", int'(stalls > 0), 1);
        end

        // Random sweep against an arithmetic model of all counts
        do_reset();
        for (int v = 0; v < NV; v++) model[v] = D;
        for (int t = 0; t < 3000; t++) begin
            bit sr, cr, acc;
            int sv, cv, m;
            @(negedge clk);
            m = 0;
            for (int v = 0; v < NV; v++) if (model[v] > 0) m |= (1 << v);
            tag = t % 3;
            if (tag == 0) chk("R3 random snd_ok vs model", int'(snd_ok), m);
            else if (tag == 1) chk("R2 random snd_ok vs model", int'(snd_ok), m);
            else chk("R4 random snd_ok vs model", int'(snd_ok), m);
            sr = ($urandom % 3) != 0;
            sv = $urandom % NV;
            cv = $urandom % NV;
            acc = sr && model[sv] > 0;
            cr = ($urandom % 2) && (model[cv] < D || (acc && sv == cv));
            snd_req = sr; snd_vc = VW'(sv); crd_rtn = cr; crd_vc = VW'(cv);
            @(posedge clk); #1;
            if (acc) model[sv]--;
            if (cr)  model[cv]++;
            snd_req = 0; crd_rtn = 0;
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule